// File: doc/BRIEF.md
# Two-Wire Bus Master Write Controller

This block is the master side of a two-wire serial bus (SMBus / I2C style) and carries out write transfers. A host raises a start request and loads a data register. The block then drives a START condition and sends an address byte: the upper seven bits of the loaded value, with the direction bit forced to 0. After that it sends as many data bytes as the host supplies. After each byte it releases SDA for a ninth clock and samples the slave's acknowledge. It sets an interrupt flag only once that ninth clock has finished, and it keeps SCL low until the host clears the flag.

When the host clears the flag, the block picks its next action. If a stop request is pending, it generates STOP and returns to idle. If a new data byte has been written, it transmits that byte. If neither is present, it falls back to a receive byte: it releases SDA for eight clocks, shifts in what the slave drives, and answers with a NACK. Both lines are open-drain. Each line has an active-high pull-low enable and a separate input from the wire. The SCL rate comes from a divider parameter.

Top module: `smb_wr_master`

## Requirements
- R1: After reset, and whenever the block is idle (`busy`=0), `scl_oe` and `sda_oe` are 0 (both lines released), and `irq` and `rx_mode` are 0.
- R2: A transfer starts only when both a start request and a loaded data byte are present. It begins with a START condition, in which SDA falls while SCL is high. A start request alone leaves the block idle.
- R3: The first byte after START is the data register's bits 7..1 followed by a 0 direction bit. For example, a loaded value of 0xB5 goes out as 0xB4.
- R4: Bytes go out MSB first, one bit per SCL clock. A data-register write that is present when the flag is cleared sends one more byte, and there is no limit on the number of bytes.
- R5: On the ninth clock of every byte the master releases SDA and samples it. `ack_status`=1 means SDA was low (ACK) and 0 means NACK. The value stays stable while `irq` is set.
- R6: `irq` is set at the end of the ninth SCL clock, after exactly 9 rising SCL edges for that byte. While `irq` is set, SCL is held low and no SCL edge occurs.
- R7: If a stop request is pending when the flag is cleared, the block generates STOP (SDA rises while SCL is high) and returns to idle. It does so even if a data byte is also pending, because stop takes priority. The stop request and any pending data byte are discarded at STOP, so the next transfer behaves normally.
- R8: If neither a stop request nor a data write is pending when the flag is cleared, `rx_mode` becomes 1 and the master keeps SDA released for all nine clocks of the next byte. It then sets `irq` with the received byte on `rx_data` (MSB first) and `ack_status`=0. A later data write returns the block to transmitting and sets `rx_mode` back to 0.
- R9: SDA changes only while SCL is low, except for START and STOP.
- R10: One SCL bit lasts 4*DIV clock cycles, with SCL low for the first half and released for the second half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_set | input | 1 | Pulse: raise start request |
| stop_set | input | 1 | Pulse: raise stop request |
| dat_wr | input | 1 | Pulse: load data register from `dat_in` |
| dat_in | input | DW | Value to load into the data register |
| irq_clr | input | 1 | Pulse: clear the byte-done flag |
| irq | output | 1 | Byte-done flag |
| ack_status | output | 1 | Acknowledge level sampled on the last ninth clock |
| rx_mode | output | 1 | Block has fallen back to receiving |
| rx_data | output | DW | Last received byte |
| busy | output | 1 | Transfer in progress |
| scl_oe | output | 1 | Pull SCL low when 1 |
| scl_in | input | 1 | SCL level on the wire |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | SDA level on the wire |

## Verification
The assertions assume that the host acts only while the flag is set. They also assume that the wire follows the block's own SCL drive with no other master and no stretching, so the slave changes SDA only while SCL is low. The bench models the wire as the AND of the block's drive and a slave model. That slave drives SDA only on falling SCL edges, for ACK bits and receive bytes. All host pulses are issued on falling clock edges while the flag is set, or while the block is idle.

// File: rtl/smbw_pkg.sv
package smbw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_TX,
    ST_ACK,
    ST_HOLD,
    ST_RX,
    ST_STOP
  } st_e;
endpackage

// File: rtl/smbw_rstsync.sv
module smbw_rstsync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/smbw_clkdiv.sv
module smbw_clkdiv #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)               cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = '0;
    else                    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = run && (cnt_q == LAST);
endmodule

// File: rtl/smbw_shreg.sv
module smbw_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         sh,
  input  logic         sin,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (ld)      q_d = ld_val;
    else if (sh) q_d = {q[W-2:0], sin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end
endmodule

// File: rtl/smb_wr_master.sv
module smb_wr_master #(
  parameter int DW  = 8,
  parameter int DIV = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_set,
  input  logic          stop_set,
  input  logic          dat_wr,
  input  logic [DW-1:0] dat_in,
  input  logic          irq_clr,
  output logic          irq,
  output logic          ack_status,
  output logic          rx_mode,
  output logic [DW-1:0] rx_data,
  output logic          busy,
  output logic          scl_oe,
  input  logic          scl_in,
  output logic          sda_oe,
  input  logic          sda_in
);
  import smbw_pkg::*;

  localparam int BCW = (DW > 2) ? $clog2(DW) : 1;
  localparam logic [BCW-1:0] LAST_BIT = BCW'(DW - 1);

  logic rst_sn;
  st_e  st_q, st_d;
  logic [1:0] ph_q, ph_d;
  logic [BCW-1:0] bit_q, bit_d;
  logic scl_q, scl_d, sda_q, sda_d;
  logic samp_q, samp_d, ack_q, ack_d, irq_q, irq_d;
  logic strt_q, strt_d, stop_q, stop_d, dpend_q, dpend_d, rxm_q, rxm_d;
  logic [DW-1:0] dreg_q, dreg_d;
  logic sr_ld, sr_sh;
  logic [DW-1:0] sr_val, sr_q;
  logic active, run, tick;

  smbw_rstsync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sn)
  );

  // Divider runs in bus-active states; high phases wait for the wire.
  assign active = (st_q == ST_START) || (st_q == ST_TX) || (st_q == ST_ACK) ||
                  (st_q == ST_RX)    || (st_q == ST_STOP);
  assign run    = active && !(ph_q[1] && !scl_in);

  smbw_clkdiv #(.DIV(DIV)) u_div (
    .clk   (clk),
    .rst_n (rst_sn),
    .run   (run),
    .tick  (tick)
  );

  smbw_shreg #(.W(DW)) u_sr (
    .clk    (clk),
    .rst_n  (rst_sn),
    .ld     (sr_ld),
    .ld_val (sr_val),
    .sh     (sr_sh),
    .sin    (samp_q),
    .q      (sr_q)
  );

  always_comb begin
    st_d    = st_q;
    ph_d    = ph_q;
    bit_d   = bit_q;
    scl_d   = scl_q;
    sda_d   = sda_q;
    samp_d  = samp_q;
    ack_d   = ack_q;
    irq_d   = irq_q;
    strt_d  = strt_q;
    stop_d  = stop_q;
    dpend_d = dpend_q;
    dreg_d  = dreg_q;
    rxm_d   = rxm_q;
    sr_ld   = 1'b0;
    sr_sh   = 1'b0;
    sr_val  = dreg_q;

    if (start_set) strt_d = 1'b1;
    if (stop_set)  stop_d = 1'b1;
    if (irq_clr)   irq_d  = 1'b0;

    case (st_q)
      ST_IDLE: begin
        if (strt_q && dpend_q) begin
          st_d    = ST_START;
          ph_d    = 2'd0;
          sr_ld   = 1'b1;
          sr_val  = {dreg_q[DW-1:1], 1'b0};
          dpend_d = 1'b0;
        end
      end
      ST_START: begin
        if (tick) begin
          ph_d = ph_q + 2'd1;
          if (ph_q == 2'd1) sda_d = 1'b1;
          if (ph_q == 2'd3) begin
            scl_d = 1'b1;
            st_d  = ST_TX;
            bit_d = '0;
          end
        end
      end
      ST_TX, ST_RX: begin
        if (tick) begin
          ph_d = ph_q + 2'd1;
          case (ph_q)
            2'd0: sda_d  = (st_q == ST_TX) ? ~sr_q[DW-1] : 1'b0;
            2'd1: scl_d  = 1'b0;
            2'd2: samp_d = sda_in;
            default: begin
              scl_d = 1'b1;
              sr_sh = 1'b1;
              if (bit_q == LAST_BIT) st_d = ST_ACK;
              else                   bit_d = bit_q + 1'b1;
            end
          endcase
        end
      end
      ST_ACK: begin
        if (tick) begin
          ph_d = ph_q + 2'd1;
          case (ph_q)
            2'd0: sda_d  = 1'b0;
            2'd1: scl_d  = 1'b0;
            2'd2: samp_d = sda_in;
            default: begin
              scl_d = 1'b1;
              st_d  = ST_HOLD;
              irq_d = 1'b1;
              ack_d = ~samp_q;
            end
          endcase
        end
      end
      ST_HOLD: begin
        if (!irq_q) begin
          ph_d  = 2'd0;
          bit_d = '0;
          if (stop_q) begin
            st_d = ST_STOP;
          end else if (dpend_q) begin
            st_d    = ST_TX;
            sr_ld   = 1'b1;
            dpend_d = 1'b0;
            rxm_d   = 1'b0;
          end else begin
            st_d  = ST_RX;
            rxm_d = 1'b1;
          end
        end
      end
      ST_STOP: begin
        if (tick) begin
          ph_d = ph_q + 2'd1;
          case (ph_q)
            2'd0: sda_d = 1'b1;
            2'd1: scl_d = 1'b0;
            2'd2: sda_d = 1'b0;
            default: begin
              st_d    = ST_IDLE;
              strt_d  = 1'b0;
              stop_d  = 1'b0;
              dpend_d = 1'b0;
              rxm_d   = 1'b0;
            end
          endcase
        end
      end
      default: st_d = ST_IDLE;
    endcase

    if (dat_wr) begin
      dreg_d  = dat_in;
      dpend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q    <= ST_IDLE;
      ph_q    <= 2'd0;
      bit_q   <= '0;
      scl_q   <= 1'b0;
      sda_q   <= 1'b0;
      samp_q  <= 1'b1;
      ack_q   <= 1'b0;
      irq_q   <= 1'b0;
      strt_q  <= 1'b0;
      stop_q  <= 1'b0;
      dpend_q <= 1'b0;
      dreg_q  <= '0;
      rxm_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      ph_q    <= ph_d;
      bit_q   <= bit_d;
      scl_q   <= scl_d;
      sda_q   <= sda_d;
      samp_q  <= samp_d;
      ack_q   <= ack_d;
      irq_q   <= irq_d;
      strt_q  <= strt_d;
      stop_q  <= stop_d;
      dpend_q <= dpend_d;
      dreg_q  <= dreg_d;
      rxm_q   <= rxm_d;
    end
  end

  assign irq        = irq_q;
  assign ack_status = ack_q;
  assign rx_mode    = rxm_q;
  assign rx_data    = sr_q;
  assign busy       = (st_q != ST_IDLE);
  assign scl_oe     = scl_q;
  assign sda_oe     = sda_q;
endmodule

// File: rtl/smbw_chk.sv
module smbw_chk (
  input logic            clk,
  input logic            rst_n,
  input smbw_pkg::st_e   st,
  input logic            scl_oe,
  input logic            sda_oe,
  input logic            irq,
  input logic            ack_status,
  input logic            busy,
  input logic            rx_mode
);
  import smbw_pkg::*;

  AST_IDLE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && !sda_oe && !irq && !rx_mode)); // R1

  AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && $past(irq)) |-> $stable(ack_status)); // R5

  AST_HOLD_SCL: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> scl_oe); // R6

  AST_IRQ_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(st) == ST_ACK)); // R6

  AST_RX_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RX) |-> !sda_oe); // R8

  AST_SDA_LOW_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && !$past(scl_oe) && (sda_oe != $past(sda_oe)))
      |-> ((st == ST_START) || (st == ST_STOP))); // R9
endmodule

bind smb_wr_master smbw_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_sn),
  .st         (st_q),
  .scl_oe     (scl_oe),
  .sda_oe     (sda_oe),
  .irq        (irq),
  .ack_status (ack_status),
  .busy       (busy),
  .rx_mode    (rx_mode)
);

// File: tb/test_smb_wr_master.sv
module test_smb_wr_master;
  localparam int CLK_P = 10;
  localparam int DW    = 8;
  localparam int DIV   = 4;

  typedef struct packed {
    logic [7:0] b;
    logic       ack;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_set = 1'b0, stop_set = 1'b0, dat_wr = 1'b0, irq_clr = 1'b0;
  logic [DW-1:0] dat_in = '0;
  logic irq, ack_status, rx_mode, busy, scl_oe, sda_oe;
  logic [DW-1:0] rx_data;

  logic ack_drv = 1'b0;
  logic rx_arm = 1'b0;
  logic [7:0] rx_pat = 8'h00;
  int rx_cnt = 0;
  logic rx_drv;
  logic scl_line, sda_line;

  assign rx_drv   = rx_arm && (rx_cnt < 8) && !rx_pat[7 - (rx_cnt & 7)];
  assign scl_line = ~scl_oe;
  assign sda_line = ~(sda_oe | ack_drv | rx_drv);

  int n_chk = 0, n_bad = 0;
  int starts = 0, stops = 0, rises = 0, bitpos = 0, bytes_ok = 0;
  logic [7:0] rb = 8'h00;
  logic ninth = 1'b1;
  logic scl_p = 1'b1, sda_p = 1'b1;
  time t_prev = 0, t_last = 0;
  exp_t exp_q[$];

  always #(CLK_P/2) clk = ~clk;

  smb_wr_master #(.DW(DW), .DIV(DIV)) i_smb_wr_master (
    .clk(clk), .rst_n(rst_n), .start_set(start_set), .stop_set(stop_set),
    .dat_wr(dat_wr), .dat_in(dat_in), .irq_clr(irq_clr), .irq(irq),
    .ack_status(ack_status), .rx_mode(rx_mode), .rx_data(rx_data), .busy(busy),
    .scl_oe(scl_oe), .scl_in(scl_line), .sda_oe(sda_oe), .sda_in(sda_line)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  // Bus monitor and slave model: pops expected bytes as they complete.
  always @(scl_line, sda_line) begin
    if (scl_line !== scl_p) begin
      if (scl_line) begin
        rises++;
        t_prev = t_last;
        t_last = $time;
        bitpos++;
        if (bitpos <= 8) rb = {rb[6:0], sda_line};
        else if (bitpos == 9) ninth = sda_line;
      end else begin
        if (bitpos >= 1 && bitpos <= 8) rx_cnt++;
        if (bitpos == 8) begin
          if (exp_q.size() == 0) chk(1'b0, "R4 unexpected byte", {24'h0, rb}, 32'h0);
          else ack_drv = exp_q[0].ack;
        end else if (bitpos == 9) begin
          ack_drv = 1'b0;
          bitpos = 0;
          rx_cnt = 0;
          if (exp_q.size() != 0) begin
            exp_t e;
            e = exp_q.pop_front();
            chk(rb == e.b, "R3/R4 byte on bus", {24'h0, rb}, {24'h0, e.b});
            chk(ninth == ~e.ack, "R5 ninth-bit level", {31'h0, ninth}, {31'h0, ~e.ack});
            bytes_ok++;
          end
        end
      end
    end else if (sda_line !== sda_p && scl_line) begin
      if (!sda_line) starts++;
      else stops++;
      bitpos = 0;
    end
    scl_p = scl_line;
    sda_p = sda_line;
  end

  task automatic host_pulse(input int which, input logic [7:0] v);
    @(negedge clk);
    case (which)
      0: start_set = 1'b1;
      1: stop_set  = 1'b1;
      2: begin dat_wr = 1'b1; dat_in = v; end
      default: irq_clr = 1'b1;
    endcase
    @(negedge clk);
    start_set = 1'b0; stop_set = 1'b0; dat_wr = 1'b0; irq_clr = 1'b0;
  endtask

  task automatic wait_irq(input string req);
    int n = 0;
    while (!irq && n < 3000) begin @(negedge clk); n++; end
    chk(irq == 1'b1, req, {31'h0, irq}, 32'h1);
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while (busy && n < 3000) begin @(negedge clk); n++; end
    chk(busy == 1'b0, req, {31'h0, busy}, 32'h0);
  endtask

  initial begin
    #(CLK_P * 200000);
    chk(1'b0, "watchdog", 32'h0, 32'h1);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int r0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk({scl_oe, sda_oe, irq, busy, rx_mode} == 5'b0, "R1 reset outputs",
        {27'h0, scl_oe, sda_oe, irq, busy, rx_mode}, 32'h0);

    // Transfer A: address then two data bytes, one NACKed
    exp_q.push_back('{b: 8'hB4, ack: 1'b1});
    host_pulse(0, 8'h00);
    host_pulse(2, 8'hB5);
    wait_irq("R6 irq after address");
    chk(starts == 1, "R2 START seen", starts, 1);
    chk(rises == 9, "R6 nine SCL rises per byte", rises, 9);
    chk(ack_status == 1'b1, "R5 ack status", {31'h0, ack_status}, 32'h1);
    chk((t_last - t_prev) == 4 * DIV * CLK_P, "R10 SCL bit period",
        32'(t_last - t_prev), 4 * DIV * CLK_P);
    r0 = rises;
    repeat (100) @(negedge clk);
    chk(rises == r0 && scl_oe == 1'b1, "R6 SCL held while flag set", rises, r0);

    exp_q.push_back('{b: 8'h3C, ack: 1'b1});
    host_pulse(2, 8'h3C);
    host_pulse(3, 8'h00);
    wait_irq("R4 irq after data");
    chk(rises == 18, "R6 rises after two bytes", rises, 18);

    exp_q.push_back('{b: 8'h81, ack: 1'b0});
    host_pulse(2, 8'h81);
    host_pulse(3, 8'h00);
    wait_irq("R4 irq after NACKed data");
    chk(ack_status == 1'b0, "R5 NACK status", {31'h0, ack_status}, 32'h0);

    // R7: stop wins over pending data
    host_pulse(2, 8'h77);
    host_pulse(1, 8'h00);
    host_pulse(3, 8'h00);
    wait_idle("R7 back to idle");
    repeat (2) @(negedge clk);
    chk(stops == 1, "R7 STOP seen", stops, 1);
    chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R7 lines released",
        {30'h0, scl_oe, sda_oe}, 32'h0);
    chk(bytes_ok == 3 && exp_q.size() == 0, "R7 no byte after stop", bytes_ok, 3);

    // Transfer B: R2 start alone does nothing
    host_pulse(0, 8'h00);
    repeat (50) @(negedge clk);
    chk(busy == 1'b0 && starts == 1, "R2 start without data stays idle", {31'h0, busy}, 32'h0);
    exp_q.push_back('{b: 8'h20, ack: 1'b1});
    host_pulse(2, 8'h20);
    wait_irq("R3 irq after address");
    chk(starts == 2, "R2 second START", starts, 2);

    // R8: fall back to receive
    exp_q.push_back('{b: 8'hC6, ack: 1'b0});
    @(negedge clk);
    rx_pat = 8'hC6;
    rx_arm = 1'b1;
    host_pulse(3, 8'h00);
    repeat (3) @(negedge clk);
    chk(rx_mode == 1'b1, "R8 rx_mode set", {31'h0, rx_mode}, 32'h1);
    wait_irq("R8 irq after receive byte");
    rx_arm = 1'b0;
    chk(rx_data == 8'hC6, "R8 received byte", {24'h0, rx_data}, 32'hC6);
    chk(ack_status == 1'b0, "R8 master NACK", {31'h0, ack_status}, 32'h0);

    exp_q.push_back('{b: 8'h99, ack: 1'b1});
    host_pulse(2, 8'h99);
    host_pulse(3, 8'h00);
    wait_irq("R4 irq after tx following rx");
    chk(rx_mode == 1'b0, "R8 rx_mode cleared by data write", {31'h0, rx_mode}, 32'h0);
    host_pulse(1, 8'h00);
    host_pulse(3, 8'h00);
    wait_idle("R7 idle after second stop");

    // Transfer C: stop request was auto-cleared
    exp_q.push_back('{b: 8'h42, ack: 1'b1});
    host_pulse(0, 8'h00);
    host_pulse(2, 8'h42);
    wait_irq("R2 irq on third transfer");
    exp_q.push_back('{b: 8'h10, ack: 1'b1});
    host_pulse(2, 8'h10);
    host_pulse(3, 8'h00);
    wait_irq("R7 stop request cleared, data continues");
    host_pulse(1, 8'h00);
    host_pulse(3, 8'h00);
    wait_idle("R7 idle after third stop");
    repeat (4) @(negedge clk);

    chk(exp_q.size() == 0, "R4 all expected bytes seen", exp_q.size(), 0);
    chk(starts == 3 && stops == 3, "R9 no stray SDA edge while SCL high",
        starts * 16 + stops, 3 * 16 + 3);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule